// File: doc/BRIEF.md
# Clock Mode and Output Controller

This block sits beside the oscillator and decides when the CPU may advance. It owns one 8-bit control register on a small register bus. The register holds two live bits. The slow-mode bit picks between a CPU clock enable that is high on every running oscillator cycle and one that is high on one cycle in 32. The clock-out bit hands a shared pin either to a square wave derived from the oscillator or back to general-purpose I/O.

A PLL start-up model gates everything. After reset, and again after a wake-up from halt, the clock stays suppressed for a start-up window. The model then steps through a locking window and a stabilisation window. A lock flag rises at the end of locking, and a settled flag rises at the end of stabilisation.

The state machine has five states:
- `PS_OFF`: halted, no clock.
- `PS_STARTUP`: counting the start-up delay, clock suppressed.
- `PS_LOCKING`: clock running, not yet locked.
- `PS_SETTLING`: locked, accuracy not yet final.
- `PS_READY`: locked and settled.

Its transitions are:
- reset → `PS_STARTUP`
- start-up done → `PS_LOCKING`
- lock done → `PS_SETTLING`
- stabilisation done → `PS_READY`
- halt request from any state → `PS_OFF`
- wake with no halt request → `PS_STARTUP`

Top module: `clkmode_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is applied, the register reads 00h, and `cpu_ce`, `pin_sel`, `pll_locked` and `pll_settled` are all 0.
- R2: A write happens when `bus_wr` is high and `bus_addr` equals REG_ADDR (default 0) at a clock edge. A write with any other address leaves the register unchanged.
- R3: With `bus_addr` equal to REG_ADDR, `bus_rdata` shows the register in the same cycle. In that value bit 0 is slow mode, bit 1 is clock-out enable, and bits 7:2 always read 0. With any other address, `bus_rdata` reads 00h.
- R4: With bit 0 clear and the clock running, `cpu_ce` is high on every cycle.
- R5: With bit 0 set, in steady state, `cpu_ce` is high on exactly one cycle in every 32.
- R6: A change of bit 0 takes effect only at a divider boundary. While the clock runs, the distance between consecutive `cpu_ce` pulses is therefore always 1 or 32.
- R7: With bit 1 clear, `pin_sel` is 0 and `pin_out` follows `gpio_out`. With bit 1 set, `pin_sel` is 1 and, while the clock runs, `pin_out` inverts on every cycle. With bit 1 set and the clock stopped, `pin_out` is 0.
- R8: After reset release, or after the edge that accepts a wake, `cpu_ce` stays 0 for STARTUP_CYC-1 edges and the clock runs from edge STARTUP_CYC (default 16).
- R9: `pll_locked` rises LOCK_CYC edges (default 24) after the clock starts. `pll_settled` rises STAB_CYC edges (default 40) after that.
- R10: The edge after `halt_i` is seen high puts the block in the halted state. There, `cpu_ce`, `pll_locked` and `pll_settled` are 0, and the register keeps its value.
- R11: A wake is accepted only in the halted state with `halt_i` low. A wake in any other state has no effect, and `halt_i` takes priority over `wake_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Halt request, level |
| wake_i | input | 1 | Wake-up request |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| gpio_out | input | 1 | General-purpose value for the shared pin |
| cpu_ce | output | 1 | CPU clock enable |
| pin_sel | output | 1 | Pin mux select, 1 = clock output |
| pin_out | output | 1 | Shared pin value |
| pll_locked | output | 1 | Lock status |
| pll_settled | output | 1 | Full-accuracy status |

## Verification
A sequencer counter or state that goes wrong shows up as `cpu_ce` or `pll_locked` switching on a cycle early or late. The bench checks every cycle of the start-up windows, so the error appears at the first boundary edge. A divider whose phase is wrong, or whose mode changes mid-count, produces a gap between `cpu_ce` pulses other than 1 or 32. That is visible within one 32-cycle period of the change. A register or mux fault appears in the same cycle on `bus_rdata` or `pin_out`.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    typedef enum logic [2:0] {
        PS_OFF      = 3'd0,
        PS_STARTUP  = 3'd1,
        PS_LOCKING  = 3'd2,
        PS_SETTLING = 3'd3,
        PS_READY    = 3'd4
    } pll_state_e;

    localparam int          CTL_SLOW_BIT = 0;
    localparam int          CTL_MCO_BIT  = 1;
    localparam logic [7:0]  CTL_RW_MASK  = 8'h03;

endpackage

// File: rtl/clkmode_reg.sv
module clkmode_reg #(
    parameter int              ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              slow_req,
    output logic              mco_en
);
    import clkmode_pkg::*;

    logic [7:0] ctrl_q;
    logic       hit;

    assign hit = (bus_addr == REG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= 8'h00;
        end else if (bus_wr && hit) begin
            ctrl_q <= bus_wdata & CTL_RW_MASK;
        end
    end

    always_comb begin
        bus_rdata = hit ? ctrl_q : 8'h00;
    end

    assign slow_req = ctrl_q[CTL_SLOW_BIT];
    assign mco_en   = ctrl_q[CTL_MCO_BIT];

    // R2: a write to another address must not touch the register
    a_r2_other_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit) |=> $stable(ctrl_q));

endmodule

// File: rtl/clkmode_pll.sv
module clkmode_pll #(
    parameter int STARTUP_CYC = 16,
    parameter int LOCK_CYC    = 24,
    parameter int STAB_CYC    = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_i,
    input  logic wake_i,
    output logic clk_run_o,
    output logic locked_o,
    output logic settled_o
);
    import clkmode_pkg::*;

    localparam int MAX_A = (STARTUP_CYC > LOCK_CYC) ? STARTUP_CYC : LOCK_CYC;
    localparam int MAX_C = (MAX_A > STAB_CYC) ? MAX_A : STAB_CYC;
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(STARTUP_CYC - 1);
    localparam logic [CNT_W-1:0] LOCK_LAST  = CNT_W'(LOCK_CYC - 1);
    localparam logic [CNT_W-1:0] STAB_LAST  = CNT_W'(STAB_CYC - 1);

    pll_state_e       state, nxt;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        nxt = state;
        if (halt_i) begin
            nxt = PS_OFF;
        end else begin
            unique case (state)
                PS_OFF:      if (wake_i)            nxt = PS_STARTUP;
                PS_STARTUP:  if (cnt == START_LAST) nxt = PS_LOCKING;
                PS_LOCKING:  if (cnt == LOCK_LAST)  nxt = PS_SETTLING;
                PS_SETTLING: if (cnt == STAB_LAST)  nxt = PS_READY;
                PS_READY:    nxt = PS_READY;
                default:     nxt = PS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PS_STARTUP;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state || nxt == PS_OFF || nxt == PS_READY) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        clk_run_o = 1'b0;
        locked_o  = 1'b0;
        settled_o = 1'b0;
        unique case (state)
            PS_OFF, PS_STARTUP: ;
            PS_LOCKING:  clk_run_o = 1'b1;
            PS_SETTLING: begin clk_run_o = 1'b1; locked_o = 1'b1; end
            PS_READY:    begin clk_run_o = 1'b1; locked_o = 1'b1; settled_o = 1'b1; end
            default: ;
        endcase
    end

    // R10: halt drops lock and clock on the next edge
    a_r10_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> (!locked_o && !clk_run_o && !settled_o));
    // R11: accepted wake starts the silent start-up window
    a_r11_wake_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_OFF && wake_i && !halt_i) |=> (state == PS_STARTUP && !clk_run_o));
    // R9: lock only ever follows a running clock
    a_r9_lock_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(clk_run_o));
    // R9: settled only ever follows lock
    a_r9_settle_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled_o) |-> $past(locked_o));

endmodule

// File: rtl/clkmode_div.sv
module clkmode_div #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow_req,
    output logic cpu_ce
);
    localparam int              CW   = $clog2(DIV);
    localparam logic [CW-1:0]   LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;
    logic          slow_act;
    logic          at_edge;

    assign at_edge = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            slow_act <= 1'b0;
        end else if (!run) begin
            cnt      <= '0;
            slow_act <= slow_req;
        end else begin
            cnt <= cnt + 1'b1;
            if (at_edge) begin
                slow_act <= slow_req;
            end
        end
    end

    always_comb begin
        cpu_ce = run && (!slow_act || at_edge);
    end

    // R5: no two pulses in a row while slow mode stays active
    a_r5_slow_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && slow_act) |=> (!cpu_ce || !slow_act));
    // R6: the active mode only changes at a boundary or while stopped
    a_r6_switch_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_act != $past(slow_act)) |-> ($past(at_edge) || !$past(run)));

endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl #(
    parameter int                ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR    = '0,
    parameter int                SLOW_DIV    = 32,
    parameter int                STARTUP_CYC = 16,
    parameter int                LOCK_CYC    = 24,
    parameter int                STAB_CYC    = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_i,
    input  logic              wake_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              gpio_out,
    output logic              cpu_ce,
    output logic              pin_sel,
    output logic              pin_out,
    output logic              pll_locked,
    output logic              pll_settled
);
    logic slow_req, mco_en, pll_run, mco_q;

    clkmode_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .slow_req(slow_req), .mco_en(mco_en)
    );

    clkmode_pll #(.STARTUP_CYC(STARTUP_CYC), .LOCK_CYC(LOCK_CYC), .STAB_CYC(STAB_CYC)) u_pll (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .wake_i(wake_i),
        .clk_run_o(pll_run), .locked_o(pll_locked), .settled_o(pll_settled)
    );

    clkmode_div #(.DIV(SLOW_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(pll_run), .slow_req(slow_req), .cpu_ce(cpu_ce)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mco_q <= 1'b0;
        end else if (pll_run && mco_en) begin
            mco_q <= ~mco_q;
        end else begin
            mco_q <= 1'b0;
        end
    end

    assign pin_sel = mco_en;
    assign pin_out = mco_en ? mco_q : gpio_out;

    // R7: the driven clock output inverts every running cycle
    a_r7_mco_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sel && $past(pin_sel && pll_run)) |-> (pin_out != $past(pin_out)));
    // R4: no CPU enable while the PLL clock is stopped
    a_r4_ce_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_run |-> !cpu_ce);

endmodule

// File: tb/clkmode_ctrl_test.sv
`timescale 1ns/1ps
module clkmode_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_i = 1'b0, wake_i = 1'b0, bus_wr = 1'b0, gpio_out = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cpu_ce, pin_sel, pin_out, pll_locked, pll_settled;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [7:0] model = 8'h00;

    always #2 clk = ~clk;

    clkmode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .wake_i(wake_i),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .gpio_out(gpio_out), .cpu_ce(cpu_ce),
        .pin_sel(pin_sel), .pin_out(pin_out), .pll_locked(pll_locked),
        .pll_settled(pll_settled)
    );

    function automatic logic [7:0] exp_read(logic [3:0] a, logic [7:0] m);
        return (a == 4'd0) ? (m & 8'h03) : 8'h00;
    endfunction

    function automatic bit gap_ok(int g);
        return (g == 1) || (g == 32);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
        if (a == 4'd0) model = d & 8'h03;
    endtask

    task automatic startup_seq(string tag);
        for (int i = 1; i <= 85; i++) begin
            tick();
            chk(cpu_ce == (i >= 16), {tag, " R8 cpu_ce"}, cpu_ce, (i >= 16));
            chk(pll_locked == (i >= 40), {tag, " R9 locked"}, pll_locked, (i >= 40));
            chk(pll_settled == (i >= 80), {tag, " R9 settled"}, pll_settled, (i >= 80));
        end
    endtask

    initial begin
        int n;
        int last;
        logic prev;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(bus_rdata == 8'h00, "R1 rdata", bus_rdata, 0);
        chk(!cpu_ce && !pin_sel && !pll_locked && !pll_settled, "R1 outputs",
            {cpu_ce, pin_sel, pll_locked, pll_settled}, 0);
        rst_n = 1'b1;
        startup_seq("reset");

        // R2 R3 random register traffic
        for (int k = 0; k < 40; k++) begin
            logic [3:0] a;
            logic [7:0] d;
            a = 4'($urandom_range(0, 3) == 0 ? 0 : $urandom_range(1, 15));
            d = 8'($urandom);
            wr(a, d);
            bus_addr = 4'd0; #1;
            chk(bus_rdata == exp_read(4'd0, model), "R2 R3 readback", bus_rdata, exp_read(4'd0, model));
            bus_addr = 4'($urandom_range(1, 15)); #1;
            chk(bus_rdata == 8'h00, "R3 other addr", bus_rdata, 0);
        end
        wr(4'd5, 8'hFF);
        bus_addr = 4'd0; #1;
        chk(bus_rdata == exp_read(4'd0, model), "R2 foreign write", bus_rdata, exp_read(4'd0, model));

        // R4 normal mode
        wr(4'd0, 8'h00);
        repeat (40) tick();
        n = 0;
        for (int k = 0; k < 50; k++) begin tick(); n += cpu_ce; end
        chk(n == 50, "R4 normal count", n, 50);

        // R5 steady slow mode
        wr(4'd0, 8'h01);
        repeat (70) tick();
        n = 0;
        for (int k = 0; k < 320; k++) begin tick(); n += cpu_ce; end
        chk(n == 10, "R5 slow count", n, 10);

        // R6 random mode switching: gaps stay 1 or 32
        last = -1;
        for (int c = 0; c < 900; c++) begin
            if (c % 45 == 7) begin
                bus_addr = 4'd0; bus_wdata = 8'($urandom & 1); bus_wr = 1'b1;
            end else begin
                bus_wr = 1'b0;
            end
            tick();
            if (cpu_ce) begin
                if (last >= 0) chk(gap_ok(c - last), "R6 pulse gap", c - last, 32);
                last = c;
            end
        end
        bus_wr = 1'b0;

        // R7 clock output and mux
        wr(4'd0, 8'h00);
        for (int k = 0; k < 10; k++) begin
            gpio_out = 1'($urandom); #1;
            chk(!pin_sel && pin_out == gpio_out, "R7 gpio pass", pin_out, gpio_out);
            tick();
        end
        wr(4'd0, 8'h02);
        tick(); tick();
        prev = pin_out;
        for (int k = 0; k < 10; k++) begin
            tick();
            chk(pin_sel && pin_out != prev, "R7 toggle", pin_out, !prev);
            prev = pin_out;
        end

        // R11 wake ignored while running
        wake_i = 1'b1; tick(); wake_i = 1'b0;
        chk(pll_locked && pll_settled && cpu_ce, "R11 wake ignored",
            {pll_locked, pll_settled, cpu_ce}, 7);

        // R10 halt
        halt_i = 1'b1; tick();
        chk(!cpu_ce && !pll_locked && !pll_settled, "R10 halted",
            {cpu_ce, pll_locked, pll_settled}, 0);
        tick();
        chk(pin_out == 1'b0, "R7 stopped pin", pin_out, 0);
        bus_addr = 4'd0; #1;
        chk(bus_rdata == 8'h02, "R10 reg kept", bus_rdata, 2);
        // R11 halt has priority over wake
        wake_i = 1'b1;
        n = 0;
        for (int k = 0; k < 20; k++) begin tick(); n += cpu_ce; end
        chk(n == 0, "R11 halt priority", n, 0);
        halt_i = 1'b0;
        tick();
        wake_i = 1'b0;
        startup_seq("wake");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule